// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block sits on a byte-wide register bus and controls an eight-channel, 8-bit successive-approximation converter. The analog parts stay outside it. The block drives a trial code toward an external DAC and reads back one comparator bit. From the control register it decodes which analog channel is selected and how many port lines are given over to analog input. For those lines it forces the digital buffer and the pull-up off.

Software starts a conversion in two steps. It first writes the start bit high, which holds the converter in reset and raises the active-low end flag. It then writes the start bit low, and the falling edge launches the conversion. The conversion clock is a divided copy of the system clock. Each conversion takes one sample slot followed by eight bit trials, most significant bit first. On completion the result is latched, the end flag drops and an interrupt request is raised. Raising the start bit again during a conversion abandons it.

Top module: `adcSarTop`

## Requirements
- R1: After reset the result, control and clock-setting registers all read 0x00. The interrupt output, the trial code and the sampling flag are all 0.
- R2: The control register sits at address 0x22 with this layout: bit 7 start, bit 6 end flag, bits 5:3 port configuration, bits 2:0 channel. The channel field appears on `chanSel`. Bus writes to bit 6 have no effect on it.
- R3: A port configuration value N puts lines 0 to N-1 in analog mode. For those lines `analogMode` is 1, `digitalEn` is 0 and `pullEn` is 0. Every other line has `digitalEn` 1 and `pullEn` equal to `pullReq`.
- R4: Writing the start bit as 1 sets the end flag to 1 from the next cycle. While the start bit is 1, the trial code is held at 0.
- R5: A conversion starts on the falling edge of the start bit. If that write takes effect at clock edge E, the end flag still reads 1 up to edge E+9·D, and the end flag is 0 and the result register is valid from edge E+1+9·D on. D is the division ratio.
- R6: During a conversion the trial code is 0 for one conversion clock (sampling). It then tries 0x80 and keeps each trial bit when `cmpHigh` is 1, meaning the input is at or above the trial code. The result is therefore the analog value seen through the comparator.
- R7: Clock-setting register bits 1:0 select the division ratio D of the conversion clock: 00 gives 2, 01 gives 8, 10 gives 32 and 11 gives 1.
- R8: Clock-setting register (address 0x23) bit 7 is a stored test bit that can be read back and has no effect on conversion timing. Bits 6:2 always read 0.
- R9: On completion an interrupt flag is set. `adcIrq` equals the flag ANDed with `irqEnable`. `irqClear` clears the flag unless a completion happens in the same cycle.
- R10: Raising the start bit during a conversion abandons it. The result register and the interrupt flag stay unchanged, and the end flag stays 1.
- R11: The result register (address 0x21) changes only at the end of a conversion. Bus writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr (combinational) |
| irqEnable | input | 1 | Interrupt enable |
| irqClear | input | 1 | Clears the interrupt flag |
| adcIrq | output | 1 | Interrupt request |
| cmpHigh | input | 1 | Comparator: input is at or above trialCode |
| trialCode | output | 8 | Code driven to the DAC |
| sampling | output | 1 | High during the sample slot |
| chanSel | output | 3 | Selected analog channel |
| analogMode | output | 8 | Per-line analog mode |
| digitalEn | output | 8 | Per-line digital buffer enable |
| pullReq | input | 8 | Per-line pull-up request from the port logic |
| pullEn | output | 8 | Per-line pull-up enable after masking |

## Verification
The sequencer's state becomes visible at the ports in two ways. The trial code changes one conversion clock after each step, and the end flag falls in exactly one cycle. A lost or repeated trial therefore shows up as a result that differs from the swept input value, and a divider or phase-count error moves the fall of the end flag off its predicted edge by at least one cycle. An abandoned conversion that leaks through shows as a changed result or a raised interrupt well after the abort. A decode error in the pin-mode logic shows immediately on the line-mode outputs.

// File: rtl/adcSarPkg.sv
package adcSarPkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int RES_BITS = 8;
  localparam int CHAN_W = 3;
  localparam int CFG_W = 3;
  localparam int LINES = 8;

  localparam logic [ADDR_W-1:0] ADDR_RESULT = 8'h21;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h22;
  localparam logic [ADDR_W-1:0] ADDR_CLKSET = 8'h23;

  // control register bit positions
  localparam int POS_START = 7;
  localparam int POS_EOC = 6;
  // clock-setting register test bit
  localparam int POS_TEST = 7;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic holdClear;   // start bit high: keep SAR cleared
    logic beginConv;   // start falling edge
    logic sampleDone;  // sample slot over, load MSB trial
    logic trialDone;   // resolve current trial bit
    logic finish;      // last trial resolved
  } convStrobe_t;

endpackage

// File: rtl/adcSarRegs.sv
module adcSarRegs
  import adcSarPkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NLINES = LINES,
  parameter int CW = CHAN_W,
  parameter int FW = CFG_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  input  logic [DW-1:0] busWrData,
  output logic [DW-1:0] busRdData,
  input  logic [DW-1:0] resultByte,
  input  logic          convDone,
  input  logic          irqEnable,
  input  logic          irqClear,
  input  logic [NLINES-1:0] pullReq,
  output logic          startBit,
  output logic [1:0]    clkSel,
  output logic [CW-1:0] chanSel,
  output logic [NLINES-1:0] analogMode,
  output logic [NLINES-1:0] digitalEn,
  output logic [NLINES-1:0] pullEn,
  output logic          eocN,
  output logic          irqFlag,
  output logic          adcIrq
);

  localparam int CFG_LO = CW;
  localparam int CFG_HI = CW + FW - 1;

  logic          ctrlWr, clkWr;
  logic          startReg, eocReg, irqReg, testBit;
  logic [FW-1:0] cfgReg;
  logic [CW-1:0] chanReg;
  logic [1:0]    clkSelReg;
  logic          unusedWrBits;

  assign ctrlWr = busWrEn && (busAddr == ADDR_CTRL);
  assign clkWr  = busWrEn && (busAddr == ADDR_CLKSET);
  assign unusedWrBits = ^busWrData[POS_TEST-1:2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startReg  <= 1'b0;
      eocReg    <= 1'b0;
      irqReg    <= 1'b0;
      testBit   <= 1'b0;
      cfgReg    <= '0;
      chanReg   <= '0;
      clkSelReg <= '0;
    end else begin
      if (ctrlWr) begin
        startReg <= busWrData[POS_START];
        cfgReg   <= busWrData[CFG_HI:CFG_LO];
        chanReg  <= busWrData[CW-1:0];
      end
      if (clkWr) begin
        testBit   <= busWrData[POS_TEST];
        clkSelReg <= busWrData[1:0];
      end
      if (ctrlWr && busWrData[POS_START]) eocReg <= 1'b1;
      else if (convDone)                  eocReg <= 1'b0;
      if (convDone)      irqReg <= 1'b1;
      else if (irqClear) irqReg <= 1'b0;
    end
  end

  // pin-mode decode: configuration N puts the lowest N lines in analog mode
  for (genvar g = 0; g < NLINES; g++) begin : gLine
    assign analogMode[g] = ({1'b0, cfgReg} > (FW+1)'(g));
    assign digitalEn[g]  = ~analogMode[g];
    assign pullEn[g]     = pullReq[g] & ~analogMode[g];
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_RESULT: busRdData = resultByte;
      ADDR_CTRL: begin
        busRdData[POS_START]     = startReg;
        busRdData[POS_EOC]       = eocReg;
        busRdData[CFG_HI:CFG_LO] = cfgReg;
        busRdData[CW-1:0]        = chanReg;
      end
      ADDR_CLKSET: begin
        busRdData[POS_TEST] = testBit;
        busRdData[1:0]      = clkSelReg;
      end
      default: busRdData = '0;
    endcase
  end

  assign startBit = startReg;
  assign clkSel   = clkSelReg;
  assign chanSel  = chanReg;
  assign eocN     = eocReg;
  assign irqFlag  = irqReg;
  assign adcIrq   = irqReg & irqEnable;

endmodule

// File: rtl/adcSarSeq.sv
module adcSarSeq
  import adcSarPkg::*;
#(
  parameter int NBITS = RES_BITS,
  parameter int DIV_SEL0 = 2,
  parameter int DIV_SEL1 = 8,
  parameter int DIV_SEL2 = 32,
  parameter int DIV_SEL3 = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startBit,
  input  logic [1:0]  clkSel,
  output convStrobe_t strb,
  output logic        busy,
  output logic        sampling
);

  localparam int DIV_MAX01 = (DIV_SEL0 > DIV_SEL1) ? DIV_SEL0 : DIV_SEL1;
  localparam int DIV_MAX23 = (DIV_SEL2 > DIV_SEL3) ? DIV_SEL2 : DIV_SEL3;
  localparam int DIV_MAX = (DIV_MAX01 > DIV_MAX23) ? DIV_MAX01 : DIV_MAX23;
  localparam int CNT_W = $clog2(DIV_MAX + 1);
  localparam int BIT_W = $clog2(NBITS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_TRIAL} seqState_t;

  seqState_t      state;
  logic [CNT_W-1:0] divCnt, divLimit;
  logic [BIT_W-1:0] bitsLeft;
  logic           startPrev, startFall, tick;

  always_comb begin
    case (clkSel)
      2'b00:   divLimit = CNT_W'(DIV_SEL0);
      2'b01:   divLimit = CNT_W'(DIV_SEL1);
      2'b10:   divLimit = CNT_W'(DIV_SEL2);
      default: divLimit = CNT_W'(DIV_SEL3);
    endcase
  end

  assign busy      = (state != ST_IDLE);
  assign sampling  = (state == ST_SAMPLE);
  assign startFall = startPrev && !startBit;
  // ">=" keeps the divider from stalling if the ratio shrinks mid-conversion
  assign tick      = busy && ((divCnt + CNT_W'(1)) >= divLimit);

  always_comb begin
    strb.holdClear  = startBit;
    strb.beginConv  = startFall;
    strb.sampleDone = (state == ST_SAMPLE) && tick && !startBit;
    strb.trialDone  = (state == ST_TRIAL) && tick && !startBit;
    strb.finish     = strb.trialDone && (bitsLeft == BIT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      bitsLeft  <= '0;
      startPrev <= 1'b0;
    end else begin
      startPrev <= startBit;
      if (startBit) begin
        state    <= ST_IDLE;
        divCnt   <= '0;
        bitsLeft <= '0;
      end else if (startFall) begin
        state  <= ST_SAMPLE;
        divCnt <= '0;
      end else if (busy) begin
        if (tick) begin
          divCnt <= '0;
          if (state == ST_SAMPLE) begin
            state    <= ST_TRIAL;
            bitsLeft <= BIT_W'(NBITS);
          end else begin
            bitsLeft <= bitsLeft - BIT_W'(1);
            if (bitsLeft == BIT_W'(1)) state <= ST_IDLE;
          end
        end else begin
          divCnt <= divCnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/adcSarPath.sv
module adcSarPath
  import adcSarPkg::*;
#(
  parameter int NBITS = RES_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  convStrobe_t      strb,
  input  logic             cmpHigh,
  output logic [NBITS-1:0] trialCode,
  output logic [NBITS-1:0] resultByte
);

  localparam logic [NBITS-1:0] TOP_BIT = {1'b1, {(NBITS-1){1'b0}}};

  logic [NBITS-1:0] sarReg, maskReg, keptCode;

  // drop the bit under trial when the input is below the trial code
  assign keptCode = cmpHigh ? sarReg : (sarReg & ~maskReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sarReg     <= '0;
      maskReg    <= '0;
      resultByte <= '0;
    end else if (strb.holdClear || strb.beginConv) begin
      sarReg  <= '0;
      maskReg <= '0;
    end else if (strb.sampleDone) begin
      sarReg  <= TOP_BIT;
      maskReg <= TOP_BIT;
    end else if (strb.trialDone) begin
      sarReg  <= keptCode | (maskReg >> 1);
      maskReg <= maskReg >> 1;
      if (strb.finish) resultByte <= keptCode;
    end
  end

  assign trialCode = sarReg;

endmodule

// File: rtl/adcSarTop.sv
module adcSarTop
  import adcSarPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   busAddr,
  input  logic         busWrEn,
  input  logic [7:0]   busWrData,
  output logic [7:0]   busRdData,
  input  logic         irqEnable,
  input  logic         irqClear,
  output logic         adcIrq,
  input  logic         cmpHigh,
  output logic [7:0]   trialCode,
  output logic         sampling,
  output logic [2:0]   chanSel,
  output logic [7:0]   analogMode,
  output logic [7:0]   digitalEn,
  input  logic [7:0]   pullReq,
  output logic [7:0]   pullEn
);

  convStrobe_t strb;
  logic        startBit, busy, eocN, irqFlag, convDone;
  logic [1:0]  clkSel;
  logic [7:0]  resultByte;

  assign convDone = strb.finish;

  adcSarRegs uRegs (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .resultByte(resultByte), .convDone(convDone),
    .irqEnable(irqEnable), .irqClear(irqClear), .pullReq(pullReq),
    .startBit(startBit), .clkSel(clkSel), .chanSel(chanSel),
    .analogMode(analogMode), .digitalEn(digitalEn), .pullEn(pullEn),
    .eocN(eocN), .irqFlag(irqFlag), .adcIrq(adcIrq)
  );

  adcSarSeq uSeq (
    .clk(clk), .rstN(rstN), .startBit(startBit), .clkSel(clkSel),
    .strb(strb), .busy(busy), .sampling(sampling)
  );

  adcSarPath uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .resultByte(resultByte)
  );

endmodule

// File: rtl/adcSarChecker.sv
module adcSarChecker (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       startBit,
  input logic       convDone,
  input logic       eocN,
  input logic       irqFlag,
  input logic [7:0] trialCode,
  input logic [7:0] resultByte
);

  AST_EOC_HIGH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> eocN);  // R5

  AST_HOLD_CLEARS_TRIAL: assert property (@(posedge clk) disable iff (!rstN)
    startBit |=> (trialCode == 8'h00));  // R4

  AST_EOC_FALL_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eocN) |-> $past(convDone));  // R5

  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> irqFlag);  // R9

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startBit) |=> !busy);  // R10

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !convDone |=> $stable(resultByte));  // R11

endmodule

bind adcSarTop adcSarChecker uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .startBit(startBit),
  .convDone(convDone), .eocN(eocN), .irqFlag(irqFlag),
  .trialCode(trialCode), .resultByte(resultByte)
);

// File: tb/tb_adcSarTop.sv
module tb_adcSarTop;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_RES = 8'h21, A_CTRL = 8'h22, A_CLK = 8'h23;

  logic       clk = 1'b0, rstN = 1'b0;
  logic [7:0] busAddr = '0, busWrData = '0, busRdData;
  logic       busWrEn = 1'b0, irqEnable = 1'b0, irqClear = 1'b0, adcIrq;
  logic       cmpHigh, sampling;
  logic [7:0] trialCode, analogMode, digitalEn, pullReq = '0, pullEn;
  logic [2:0] chanSel;
  logic [7:0] vin = '0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmpHigh = (vin >= trialCode);

  adcSarTop dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqEnable(irqEnable),
    .irqClear(irqClear), .adcIrq(adcIrq), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .sampling(sampling), .chanSel(chanSel),
    .analogMode(analogMode), .digitalEn(digitalEn), .pullReq(pullReq),
    .pullEn(pullEn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  // full conversion with end-flag timing check; div is the expected ratio
  task automatic runConv(input logic [7:0] v, input int div, input string tag);
    logic [7:0] rd;
    vin = v;
    busWrite(A_CTRL, 8'h80);
    readReg(A_CTRL, rd);
    check(rd[6] == 1'b1, {tag, " R4 end flag set by start"}, rd[6], 1);
    busWrite(A_CTRL, 8'h00);
    repeat (9*div) @(negedge clk);
    readReg(A_CTRL, rd);
    check(rd[6] == 1'b1, {tag, " R5 end flag still high before last edge"}, rd[6], 1);
    @(negedge clk);
    readReg(A_CTRL, rd);
    check(rd[6] == 1'b0, {tag, " R5 end flag low after completion"}, rd[6], 0);
    readReg(A_RES, rd);
    check(rd == v, {tag, " R6 result equals input"}, rd, v);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd, expMask, prevRes;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(A_RES, rd);  check(rd == 8'h00, "R1 result reset", rd, 0);
    readReg(A_CTRL, rd); check(rd == 8'h00, "R1 control reset", rd, 0);
    readReg(A_CLK, rd);  check(rd == 8'h00, "R1 clock reg reset", rd, 0);
    check(adcIrq == 1'b0 && trialCode == 8'h00 && sampling == 1'b0,
          "R1 outputs idle", {adcIrq, sampling, trialCode}, 0);

    // R3 pin configuration sweep, R2 channel field
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int p = 0; p < 2; p++) begin
        pullReq = (p == 0) ? 8'hFF : 8'hA5;
        busWrite(A_CTRL, 8'((cfg << 3) | (7 - cfg)));
        expMask = 8'((1 << cfg) - 1);
        check(analogMode == expMask, "R3 analog lines", analogMode, expMask);
        check(digitalEn == ~expMask, "R3 digital enable", digitalEn, ~expMask);
        check(pullEn == (pullReq & ~expMask), "R3 pull masking", pullEn, pullReq & ~expMask);
        check(chanSel == 3'(7 - cfg), "R2 channel output", chanSel, 7 - cfg);
      end
    end

    // R7 ratio 1, R6 bit sequence for extreme inputs
    busWrite(A_CLK, 8'h03);
    for (int e = 0; e < 2; e++) begin
      vin = (e == 0) ? 8'h00 : 8'hFF;
      busWrite(A_CTRL, 8'h80);
      busWrite(A_CTRL, 8'h00);
      @(negedge clk);
      check(trialCode == 8'h00 && sampling, "R6 sample slot code", trialCode, 0);
      @(negedge clk);
      check(trialCode == 8'h80, "R6 first trial MSB", trialCode, 8'h80);
      @(negedge clk);
      check(trialCode == ((e == 0) ? 8'h40 : 8'hC0), "R6 second trial",
            trialCode, (e == 0) ? 8'h40 : 8'hC0);
      repeat (7) @(negedge clk);
      readReg(A_RES, rd);
      check(rd == vin, "R6 sequence result", rd, vin);
    end

    // R6 exhaustive sweep at ratio 1 (R7 select 11)
    for (int v = 0; v < 256; v++) runConv(8'(v), 1, "R7 sel11");

    // R7 other ratios
    busWrite(A_CLK, 8'h00);
    runConv(8'h5A, 2, "R7 sel00");
    runConv(8'h01, 2, "R7 sel00");
    busWrite(A_CLK, 8'h01);
    runConv(8'hA5, 8, "R7 sel01");
    busWrite(A_CLK, 8'h02);
    runConv(8'h7F, 32, "R7 sel10");

    // R8 test bit stored, no timing effect, unused bits read 0
    busWrite(A_CLK, 8'hFF);
    readReg(A_CLK, rd);
    check(rd == 8'h83, "R8 clock reg readback", rd, 8'h83);
    runConv(8'h3C, 1, "R8 test bit set");
    busWrite(A_CLK, 8'h80);
    runConv(8'hC3, 2, "R8 test bit with sel00");

    // R2 write to end flag ignored (flag currently 0)
    busWrite(A_CTRL, 8'h7F);
    readReg(A_CTRL, rd);
    check(rd == 8'h3F, "R2 end flag not writable", rd, 8'h3F);
    busWrite(A_CTRL, 8'h00);

    // R11 result not writable
    busWrite(A_RES, 8'hAA);
    readReg(A_RES, rd);
    check(rd == 8'hC3, "R11 result write ignored", rd, 8'hC3);

    // R9 interrupt gating and clear
    check(adcIrq == 1'b0, "R9 masked when disabled", adcIrq, 0);
    irqEnable = 1'b1; #1;
    check(adcIrq == 1'b1, "R9 pending flag shown", adcIrq, 1);
    @(negedge clk); irqClear = 1'b1; @(negedge clk); irqClear = 1'b0;
    check(adcIrq == 1'b0, "R9 cleared", adcIrq, 0);
    busWrite(A_CLK, 8'h01);
    vin = 8'h66;
    busWrite(A_CTRL, 8'h80);
    busWrite(A_CTRL, 8'h00);
    repeat (72) @(negedge clk);
    check(adcIrq == 1'b0, "R9 not yet raised", adcIrq, 0);
    @(negedge clk);
    check(adcIrq == 1'b1, "R9 raised on completion", adcIrq, 1);
    @(negedge clk); irqClear = 1'b1; @(negedge clk); irqClear = 1'b0;

    // R10 abort mid-conversion
    readReg(A_RES, prevRes);
    vin = 8'h33;
    busWrite(A_CTRL, 8'h80);
    busWrite(A_CTRL, 8'h00);
    repeat (30) @(negedge clk);
    busWrite(A_CTRL, 8'h80);
    @(negedge clk);
    check(trialCode == 8'h00, "R10 SAR reset on abort", trialCode, 0);
    repeat (150) @(negedge clk);
    readReg(A_RES, rd);
    check(rd == prevRes, "R10 result unchanged", rd, prevRes);
    readReg(A_CTRL, rd);
    check(rd[6] == 1'b1, "R10 end flag stays high", rd[6], 1);
    check(adcIrq == 1'b0, "R10 no interrupt", adcIrq, 0);
    runConv(8'h33, 8, "R10 restart");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule